// File: doc/BRIEF.md
# Dual-Style Host Bus Bridge

This block connects an external byte-wide microprocessor bus to the read and write strobes of an internal register file. Two static strap inputs set how it works. The first strap picks the bus style. With the strap low, the bus uses chip select, an address strobe, a read/write direction line and a data strobe, and the full 12-bit register address comes from dedicated address pins. With the strap high, the bus uses chip select, an address latch enable, a read strobe and a write strobe. In that style only the top address bits come from dedicated pins, and the low address byte is taken from the shared data bus.

The second strap picks the timing. In the asynchronous setting, every bus input goes through a two-flop synchronizer into the block's clock domain. In the synchronous setting, the processor runs from the block's clock, so one register stage is enough. Each register access produces a single one-cycle strobe toward the register file, along with the address and, for a write, the data. The data bus is driven back to the processor only while a read is under way. Outside that window the pad driver is disabled through an output-enable line.

Top module: `hostbus_bridge`

## Requirements
- R1: After a synchronous reset with idle bus inputs, `reg_rd`, `reg_wr` and `bus_ad_oe` are 0, and `reg_addr` and `reg_wdata` are 0.
- R2: With `strap_ale`=0, the register address is the full value on `bus_addr[11:0]`, captured on the falling edge of the active-low address strobe `bus_astb`.
- R3: With `strap_ale`=1, the register address is {`bus_addr[11:8]`, `bus_ad_in[7:0]`}, captured on the falling edge of the active-high latch enable `bus_astb`. In this style `bus_addr[7:0]` has no effect.
- R4: A write access (`strap_ale`=0: `bus_ds_wr` low with `bus_rw_rd`=0; `strap_ale`=1: `bus_ds_wr` low as write strobe) gives exactly one `reg_wr` pulse, one cycle wide, when the strobe deasserts. The pulse carries the captured address and the last `bus_ad_in` value seen while the strobe was asserted.
- R5: A read access (`strap_ale`=0: `bus_ds_wr` low with `bus_rw_rd`=1; `strap_ale`=1: `bus_rw_rd` low as read strobe) gives exactly one one-cycle `reg_rd` pulse when the strobe asserts, with the captured address on `reg_addr`.
- R6: `bus_ad_oe` is 1 exactly while `bus_cs_n` is low and the read condition of R5 holds at the pins. While it is 1, `bus_ad_out` equals `reg_rdata`.
- R7: Assume a write strobe is released before clock edge k. With `strap_sync`=0, `reg_wr` is high in the cycle after edge k+2. With `strap_sync`=1, it is high in the cycle after edge k+1.
- R8: While `bus_cs_n` is high, strobe activity gives no `reg_rd` or `reg_wr` pulse, and `bus_ad_oe` stays 0.
- R9: If a new address capture falls in the same cycle as the end of a write, the write still uses the previous address. The next access uses the new one.
- R10: `reg_rd` and `reg_wr` are never high together. If a read start and a write end are seen in the same cycle, `reg_wr` is issued first and `reg_rd` follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. In synchronous mode this is also the processor clock. |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_ale | input | 1 | Bus style: 0 = address/data strobe style, 1 = latch-enable style with multiplexed address |
| strap_sync | input | 1 | 0 = asynchronous inputs (two-flop sync), 1 = synchronous inputs |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_astb | input | 1 | Address strobe (style 0, active low) or address latch enable (style 1, active high) |
| bus_rw_rd | input | 1 | Read/write direction, 1 = read (style 0), or read strobe, active low (style 1) |
| bus_ds_wr | input | 1 | Data strobe (style 0) or write strobe (style 1), active low |
| bus_addr | input | 12 | Dedicated address pins |
| bus_ad_in | input | 8 | Shared address/data bus, input side |
| bus_ad_out | output | 8 | Shared address/data bus, output side |
| bus_ad_oe | output | 1 | Output enable for the shared bus pad driver |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_addr | output | 12 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data returned for `reg_addr` |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the end of a write and the capture of the next address. The bench provokes it in latch-enable style by raising the latch enable while the write strobe is still low, then lowering both together. It then checks that the write carries the old address and that the following read uses the new one. The second pair is a read start and a write end. The bench provokes it in strobe style by flipping the direction line while the data strobe stays low. It then checks that the write pulse comes first and the read pulse follows exactly one cycle later.

// File: rtl/hb_pkg.sv
// Package: shared widths for the host bus bridge.
// Assumes the address is wider than the data byte (multiplexed style needs it).
package hb_pkg;
    parameter int HB_ADDR_W = 12;
    parameter int HB_DATA_W = 8;
    parameter int HB_CTRL_W = 4;
    localparam int HB_HI_W  = HB_ADDR_W - HB_DATA_W;
endpackage

// File: rtl/hb_sync.sv
// hb_sync: input register chain for the whole bus bundle.
// With sync_mode low the output is taken after STAGES flops (metastability
// protection for asynchronous pins). With sync_mode high it is taken after
// the first flop. Multi-bit buses are assumed stable while their strobe is
// valid, so they are simply delayed alongside the controls.
module hb_sync #(
    parameter int          W       = 24,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_mode,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // Shift the bundle through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    // Pick the tap that matches the timing strap
    always_comb begin
        q = sync_mode ? st[0] : st[STAGES-1];
    end
endmodule

// File: rtl/hb_decode.sv
// hb_decode: turns the synchronized pins into read/write activity levels and
// latches the register address on the falling edge of the address strobe
// (style 0) or latch enable (style 1). Assumes straps are static after reset.
module hb_decode
    import hb_pkg::*;
#(
    parameter int ADDR_W = HB_ADDR_W,
    parameter int DATA_W = HB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_ale,
    input  logic              cs_n,
    input  logic              astb,
    input  logic              rw_rd,
    input  logic              ds_wr,
    input  logic [ADDR_W-1:0] a,
    input  logic [DATA_W-1:0] ad,
    output logic              rd_act,
    output logic              wr_act,
    output logic [ADDR_W-1:0] addr_lat,
    output logic [ADDR_W-1:0] addr_next
);
    logic              astb_prev;
    logic              cap;
    logic [ADDR_W-1:0] cap_addr;

    // Decode read and write activity for the selected bus style
    always_comb begin
        if (style_ale) begin
            rd_act = !cs_n && !rw_rd;
            wr_act = !cs_n && !ds_wr;
        end else begin
            rd_act = !cs_n && !ds_wr && rw_rd;
            wr_act = !cs_n && !ds_wr && !rw_rd;
        end
    end

    // Detect the capture edge and form the address being captured
    always_comb begin
        cap       = astb_prev && !astb;
        cap_addr  = style_ale ? {a[ADDR_W-1:DATA_W], ad} : a;
        addr_next = cap ? cap_addr : addr_lat;
    end

    // Keep the previous strobe level and hold the latched address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            astb_prev <= 1'b1;
            addr_lat  <= '0;
        end else begin
            astb_prev <= astb;
            if (cap) addr_lat <= cap_addr;
        end
    end

    // R3: in latch-enable style the high address bits come from the dedicated pins
    p_mux_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (style_ale && astb_prev && !astb)
        |=> (addr_lat[ADDR_W-1:DATA_W] == $past(a[ADDR_W-1:DATA_W])));

    // R2: in strobe style the whole address comes from the dedicated pins
    p_full_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!style_ale && astb_prev && !astb) |=> (addr_lat == $past(a)));
endmodule

// File: rtl/hb_access.sv
// hb_access: produces one-cycle register strobes. A read fires when read
// activity starts, a write fires when write activity ends. Write data is the
// last bus value seen while the write was active. A read start that
// coincides with a write end is deferred by one cycle.
module hb_access
    import hb_pkg::*;
#(
    parameter int ADDR_W = HB_ADDR_W,
    parameter int DATA_W = HB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] ad,
    input  logic [ADDR_W-1:0] addr_lat,
    input  logic [ADDR_W-1:0] addr_next,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    logic              rd_prev;
    logic              wr_prev;
    logic              rd_pend;
    logic              rd_rise;
    logic              wr_fall;
    logic [DATA_W-1:0] wd_lat;

    // Edge detection on the activity levels
    always_comb begin
        rd_rise = rd_act && !rd_prev;
        wr_fall = wr_prev && !wr_act;
    end

    // Track activity history and sample write data while the write is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
            wd_lat  <= '0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
            if (wr_act) wd_lat <= ad;
        end
    end

    // Issue strobes, address and data toward the register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            rd_pend   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_wr  <= wr_fall;
            reg_rd  <= 1'b0;
            rd_pend <= 1'b0;
            if (wr_fall) begin
                reg_addr  <= addr_lat;
                reg_wdata <= wd_lat;
                rd_pend   <= rd_rise;
            end else if (rd_rise) begin
                reg_rd   <= 1'b1;
                reg_addr <= addr_next;
            end else if (rd_pend) begin
                reg_rd   <= 1'b1;
                reg_addr <= addr_lat;
            end
        end
    end

    // R4: a write strobe is a single cycle wide
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5: a read strobe is a single cycle wide
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R10: the two strobes never overlap
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R10: a read start that coincides with a write end is issued one cycle later
    p_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !rd_prev && wr_prev && !wr_act) |=> ##1 reg_rd);
endmodule

// File: rtl/hostbus_bridge.sv
// hostbus_bridge: top of the byte-wide host bus bridge. Straps pick the bus
// style and the timing mode and are assumed static (change only in reset).
// The read-data output enable is decoded straight from the pins, so the pad
// releases the bus as soon as the processor ends the read.
module hostbus_bridge
    import hb_pkg::*;
#(
    parameter int ADDR_W      = HB_ADDR_W,
    parameter int DATA_W      = HB_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ale,
    input  logic              strap_sync,
    input  logic              bus_cs_n,
    input  logic              bus_astb,
    input  logic              bus_rw_rd,
    input  logic              bus_ds_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int BUN_W = HB_CTRL_W + ADDR_W + DATA_W;
    localparam logic [BUN_W-1:0] BUN_RST = {{HB_CTRL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUN_W-1:0]  bun_raw;
    logic [BUN_W-1:0]  bun_s;
    logic              s_cs_n;
    logic              s_astb;
    logic              s_rw_rd;
    logic              s_ds_wr;
    logic [ADDR_W-1:0] s_a;
    logic [DATA_W-1:0] s_ad;
    logic              rd_act;
    logic              wr_act;
    logic [ADDR_W-1:0] addr_lat;
    logic [ADDR_W-1:0] addr_next;

    // Bundle pins for the synchronizer and split the result again
    always_comb begin
        bun_raw = {bus_cs_n, bus_astb, bus_rw_rd, bus_ds_wr, bus_addr, bus_ad_in};
        {s_cs_n, s_astb, s_rw_rd, s_ds_wr, s_a, s_ad} = bun_s;
    end

    generate
        if (SYNC_STAGES < 2) begin : g_min_stages
            // A single stage cannot protect asynchronous pins; force two
            hb_sync #(.W(BUN_W), .STAGES(2), .RST_VAL(BUN_RST)) u_sync (
                .clk(clk), .rst_n(rst_n), .sync_mode(strap_sync),
                .d(bun_raw), .q(bun_s));
        end else begin : g_cfg_stages
            hb_sync #(.W(BUN_W), .STAGES(SYNC_STAGES), .RST_VAL(BUN_RST)) u_sync (
                .clk(clk), .rst_n(rst_n), .sync_mode(strap_sync),
                .d(bun_raw), .q(bun_s));
        end
    endgenerate

    hb_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .style_ale (strap_ale),
        .cs_n      (s_cs_n),
        .astb      (s_astb),
        .rw_rd     (s_rw_rd),
        .ds_wr     (s_ds_wr),
        .a         (s_a),
        .ad        (s_ad),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .addr_lat  (addr_lat),
        .addr_next (addr_next)
    );

    hb_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .ad        (s_ad),
        .addr_lat  (addr_lat),
        .addr_next (addr_next),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    // Drive read data onto the shared bus only during a selected read
    always_comb begin
        bus_ad_oe  = !bus_cs_n && (strap_ale ? !bus_rw_rd : (!bus_ds_wr && bus_rw_rd));
        bus_ad_out = bus_ad_oe ? reg_rdata : '0;
    end

    // R6/R8: the data bus is never driven without chip select
    p_oe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> !bus_cs_n);

    // R8: no register strobe appears while chip select has been high throughout
    p_no_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n && $past(bus_cs_n) && $past(bus_cs_n, 2) && $past(bus_cs_n, 3)
         && $past(bus_cs_n, 4) && $past(rst_n, 4))
        |-> (!reg_rd && !reg_wr));
endmodule

// File: tb/hostbus_bridge_tb.sv
`timescale 1ns/1ps
module hostbus_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_ale = 1'b0;
    logic        strap_sync = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_astb = 1'b1;
    logic        bus_rw_rd = 1'b1;
    logic        bus_ds_wr = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_ad_in = '0;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic        reg_rd;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    int wr_cnt = 0, rd_cnt = 0;
    int wr_cyc = 0, rd_cyc = 0;
    logic [11:0] wr_addr_seen = '0, rd_addr_seen = '0;
    logic [7:0]  wr_data_seen = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hostbus_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .strap_ale(strap_ale), .strap_sync(strap_sync),
        .bus_cs_n(bus_cs_n), .bus_astb(bus_astb), .bus_rw_rd(bus_rw_rd),
        .bus_ds_wr(bus_ds_wr), .bus_addr(bus_addr), .bus_ad_in(bus_ad_in),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata));

    // Register file model: read data is a fixed function of the address
    function automatic logic [7:0] rdata_of(input logic [11:0] ad);
        return ad[7:0] ^ {ad[11:8], ad[11:8]} ^ 8'h96;
    endfunction
    assign reg_rdata = rdata_of(reg_addr);

    // Expected register address for a given style
    function automatic logic [11:0] exp_addr(input logic ale, input logic [11:0] pins,
                                             input logic [7:0] lo);
        return ale ? {pins[11:8], lo} : pins;
    endfunction

    // Monitor strobes away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (reg_wr) begin
            wr_cnt++; wr_cyc = cyc; wr_addr_seen = reg_addr; wr_data_seen = reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt++; rd_cyc = cyc; rd_addr_seen = reg_addr;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_idle();
        bus_cs_n = 1'b1; bus_rw_rd = 1'b1; bus_ds_wr = 1'b1;
        bus_astb = strap_ale ? 1'b0 : 1'b1;
    endtask

    task automatic go_mode(input logic ale, input logic syn);
        @(negedge clk);
        rst_n = 1'b0; strap_ale = ale; strap_sync = syn;
        set_idle();
        waitn(3);
        rst_n = 1'b1;
        waitn(4);
    endtask

    // Present an address in the current style
    task automatic put_addr(input logic [11:0] ad, output logic [7:0] lo_used);
        logic [11:0] pins;
        pins = {ad[11:8], 8'($urandom)};
        if (strap_ale) begin
            bus_astb = 1'b1; bus_addr = pins; bus_ad_in = ad[7:0];
            waitn(2);
            bus_astb = 1'b0;
            waitn(1);
            lo_used = ad[7:0];
        end else begin
            bus_addr = ad; bus_astb = 1'b0;
            waitn(1);
            lo_used = ad[7:0];
        end
    endtask

    task automatic do_write(input logic [11:0] ad, input logic [7:0] dt,
                            input bit use_cs, output int lat);
        logic [7:0] lo;
        put_addr(ad, lo);
        bus_cs_n = !use_cs; bus_ad_in = dt;
        if (!strap_ale) bus_rw_rd = 1'b0;
        bus_ds_wr = 1'b0;
        waitn(4);
        check(bus_ad_oe == 1'b0, "R6 oe during write", bus_ad_oe, 0);
        bus_ds_wr = 1'b1; bus_ad_in = 8'($urandom);
        lat = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (reg_wr && lat == 0) lat = i;
        end
        set_idle();
        waitn(2);
    endtask

    task automatic do_read(input logic [11:0] ad, input bit use_cs);
        logic [7:0] lo;
        put_addr(ad, lo);
        bus_cs_n = !use_cs; bus_ad_in = 8'($urandom);
        if (strap_ale) bus_rw_rd = 1'b0;
        else begin bus_rw_rd = 1'b1; bus_ds_wr = 1'b0; end
        waitn(5);
        check(bus_ad_oe == use_cs, "R6 oe during read", bus_ad_oe, use_cs);
        if (use_cs)
            check(bus_ad_out == rdata_of(ad), "R6 read data on bus", bus_ad_out, rdata_of(ad));
        set_idle();
        #0.1;
        check(bus_ad_oe == 1'b0, "R6 oe released", bus_ad_oe, 0);
        waitn(6);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, w0, r0;
        logic [11:0] ad;
        logic [7:0] dt;
        void'($urandom(32'h5EED_2024));

        // R1: reset state
        go_mode(1'b0, 1'b0);
        check(reg_rd == 0 && reg_wr == 0, "R1 strobes after reset", {reg_rd, reg_wr}, 0);
        check(bus_ad_oe == 0, "R1 oe after reset", bus_ad_oe, 0);
        check(reg_addr == 0 && reg_wdata == 0, "R1 addr/data after reset", {reg_addr, reg_wdata}, 0);

        // R7: latency in each timing mode, strobe style
        w0 = wr_cnt;
        do_write(12'hA5C, 8'h3E, 1, lat);
        check(lat == 3, "R7 async write latency", lat, 3);
        check(wr_cnt == w0 + 1, "R4 one write pulse", wr_cnt - w0, 1);
        go_mode(1'b0, 1'b1);
        do_write(12'h17F, 8'hC1, 1, lat);
        check(lat == 2, "R7 sync write latency", lat, 2);
        check(wr_addr_seen == 12'h17F && wr_data_seen == 8'hC1, "R2 R4 sync write",
              {wr_addr_seen, wr_data_seen}, {12'h17F, 8'hC1});

        // R8: chip select high blocks both access kinds
        w0 = wr_cnt; r0 = rd_cnt;
        do_write(12'h222, 8'h11, 0, lat);
        do_read(12'h333, 0);
        check(wr_cnt == w0 && rd_cnt == r0, "R8 no strobe without cs",
              (wr_cnt - w0) + (rd_cnt - r0), 0);

        // R10: read start coincides with write end (direction flips under strobe)
        w0 = wr_cnt; r0 = rd_cnt;
        bus_addr = 12'h4D2; bus_astb = 1'b0; waitn(1);
        bus_cs_n = 1'b0; bus_rw_rd = 1'b0; bus_ad_in = 8'h6B; bus_ds_wr = 1'b0;
        waitn(4);
        bus_rw_rd = 1'b1;
        waitn(6);
        set_idle(); waitn(4);
        check(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R10 both strobes issued",
              (wr_cnt - w0) * 16 + (rd_cnt - r0), 17);
        check(rd_cyc == wr_cyc + 1, "R10 read one cycle after write", rd_cyc - wr_cyc, 1);
        check(wr_data_seen == 8'h6B && rd_addr_seen == 12'h4D2, "R10 addr/data",
              {wr_data_seen, rd_addr_seen}, {8'h6B, 12'h4D2});

        // R9: capture of next address coincides with write end (latch-enable style)
        go_mode(1'b1, 1'b0);
        bus_astb = 1'b1; bus_addr = 12'h3FF; bus_ad_in = 8'hA5; waitn(2);
        bus_astb = 1'b0; waitn(1);
        bus_cs_n = 1'b0; bus_ad_in = 8'h5C; bus_ds_wr = 1'b0; waitn(4);
        bus_astb = 1'b1; bus_addr = 12'hC00; waitn(2);
        bus_astb = 1'b0; bus_ds_wr = 1'b1; waitn(6);
        check(wr_addr_seen == 12'h3A5 && wr_data_seen == 8'h5C, "R9 write keeps old address",
              {wr_addr_seen, wr_data_seen}, {12'h3A5, 8'h5C});
        r0 = rd_cnt;
        bus_rw_rd = 1'b0; waitn(5);
        bus_rw_rd = 1'b1; bus_cs_n = 1'b1; waitn(4);
        check(rd_cnt == r0 + 1 && rd_addr_seen == 12'hC5C, "R9 R3 next access uses new address",
              rd_addr_seen, 12'hC5C);

        // Random accesses across all four strap settings
        for (int m = 0; m < 4; m++) begin
            go_mode(m[1], m[0]);
            for (int i = 0; i < 12; i++) begin
                ad = 12'($urandom); dt = 8'($urandom);
                if ($urandom % 2) begin
                    w0 = wr_cnt;
                    do_write(ad, dt, 1, lat);
                    check(wr_cnt == w0 + 1, "R4 single write pulse", wr_cnt - w0, 1);
                    check(wr_addr_seen == exp_addr(m[1], ad, ad[7:0]),
                          m[1] ? "R3 write address" : "R2 write address",
                          wr_addr_seen, ad);
                    check(wr_data_seen == dt, "R4 write data", wr_data_seen, dt);
                    check(lat == (m[0] ? 2 : 3), "R7 write latency", lat, m[0] ? 2 : 3);
                end else begin
                    r0 = rd_cnt;
                    do_read(ad, 1);
                    check(rd_cnt == r0 + 1, "R5 single read pulse", rd_cnt - r0, 1);
                    check(rd_addr_seen == exp_addr(m[1], ad, ad[7:0]),
                          m[1] ? "R3 read address" : "R5 read address",
                          rd_addr_seen, ad);
                end
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule